// File: doc/BRIEF.md
# Blocking Fetch and Data Access Sequencer

This block is the control state machine of a single-issue core that is not pipelined. It keeps only one memory transaction open at a time. It fetches one instruction. When a stub decoder marks that instruction as a load or store that is not a prefetch, the block issues one data access. It waits for each response before it moves on. Both memory ports use a combinational request/accept handshake. When a port refuses a request, the block holds that request and presents it again only in a cycle where the port signals retry.

The block also provides run-control operations for the surrounding system:
- Activation with a programmable start-up delay in cycles.
- Suspension back to idle.
- Switch-out, and take-over after a switch-out.
- Resume.
- Quiescing (drain). A drain completes at once when the core holds no open transaction. Otherwise it completes at the next memory response, and the fetched or loaded instruction is dropped. Fetching then stays stopped until resume.

Top module: `blocking_mem_seq`

## Requirements
- R1: A synchronous active-high reset gives state code 0 (idle), PC equal to RESET_PC, and no port request. The draining, retire, drain_ack, drain_done and error outputs are all clear.
- R2: In state 1 (running), when a fetch is pending, its delay has elapsed and neither suspend nor switch-out is present, ifetch_req_o rises with the PC on ifetch_addr_o. If the port accepts, the next state is 3 (fetch wait). If the port refuses, the next state is 2 (fetch retry).
- R3: In state 2, ifetch_req_o is asserted only in cycles where ifetch_retry_i is high. An accept in such a cycle moves the block to state 3. In any other case it stays in state 2.
- R4: When fetch_fault_i is high at issue time, no fetch request is sent. The PC becomes TRAP_PC, retire_o pulses, and the next fetch is issued in the following cycle.
- R5: A fetch response in state 3 returns the block to state 1. If dec_memref_i is high and dec_prefetch_i is low, dmem_req_o rises in the same cycle; accept leads to state 5 (data wait) and refuse to state 4 (data retry). Any other instruction, including a prefetch, retires at once and the PC advances by STEP.
- R6: In state 4, dmem_req_o is asserted only in cycles where dmem_retry_i is high. An accept in such a cycle moves the block to state 5. In any other case it stays in state 4.
- R7: A data response in state 5 returns the block to state 1. It pulses retire_o, advances the PC by STEP, and the next fetch is issued in the following cycle.
- R8: A drain request in state 0, 1 or 6 pulses drain_ack_o in the next cycle. In any other state it sets draining_o. The next fetch or data response then returns the block to state 1, pulses drain_done_o and clears draining_o. That response causes no retire, no PC change and no data request, and no fetch starts until resume.
- R9: Suspend in state 1 moves the block to state 0 and no fetch is issued in that cycle. In every other state suspend is ignored.
- R10: Activate in state 0 moves the block to state 1 with delay D from act_delay_i. The first fetch request appears in the (D+1)-th cycle spent in state 1. In any other state activate is ignored.
- R11: Switch-out in state 0 or 1 moves the block to state 6 and cancels any pending delayed fetch. Take-over in state 6 moves the block to state 1 with no fetch pending. Resume outside states 0 and 6 sets a fetch pending with no delay; in states 0 and 6 resume is ignored.
- R12: proto_err_o is sticky until reset. It is set by any of the following: a fetch response outside state 3, a data response outside state 5, a fetch retry outside state 2, or a data retry outside state 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| activate_i | input | 1 | Start the core from idle |
| act_delay_i | input | DW | Cycles to wait before the first fetch after activation |
| suspend_i | input | 1 | Return to idle from running |
| switch_out_i | input | 1 | Hand the core off; go to switched-out |
| take_over_i | input | 1 | Leave switched-out into running, with no fetch pending |
| resume_i | input | 1 | Restart fetching |
| drain_req_i | input | 1 | Request quiescing |
| fetch_fault_i | input | 1 | Fetch for the current PC would fault |
| ifetch_req_o | output | 1 | Instruction port request |
| ifetch_addr_o | output | AW | Fetch address (current PC) |
| ifetch_accept_i | input | 1 | Instruction port accepts the request this cycle |
| ifetch_retry_i | input | 1 | Instruction port invites a refused request again |
| ifetch_resp_i | input | 1 | Instruction response |
| dec_memref_i | input | 1 | Fetched instruction is a load or store |
| dec_prefetch_i | input | 1 | Fetched instruction is a data prefetch |
| dmem_req_o | output | 1 | Data port request |
| dmem_accept_i | input | 1 | Data port accepts the request this cycle |
| dmem_retry_i | input | 1 | Data port invites a refused request again |
| dmem_resp_i | input | 1 | Data response |
| state_o | output | 3 | State code 0..6 |
| retire_o | output | 1 | An instruction completed in the last cycle |
| drain_ack_o | output | 1 | Immediate drain acknowledge |
| drain_done_o | output | 1 | Deferred drain completed |
| draining_o | output | 1 | Drain is pending |
| proto_err_o | output | 1 | Sticky protocol error |

## Verification
Two events can fall in the same cycle: a drain request and the memory response that would complete the open transaction. In that case the response completes normally and the drain stays pending for the next response. A drain already pending takes the response over instead. Directed cases set up both orderings. Random stimulus also raises drain, resume and suspend requests at the same time as responses and retries. Each cycle a bench model that follows the requirements judges retire, the PC, drain_done and whether a data request was issued.

// File: rtl/bms_pkg.sv
package bms_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_IRETRY = 3'd2,
        ST_IWAIT  = 3'd3,
        ST_DRETRY = 3'd4,
        ST_DWAIT  = 3'd5,
        ST_SWOUT  = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        PC_HOLD = 2'd0,
        PC_STEP = 2'd1,
        PC_TRAP = 2'd2
    } pc_op_e;

    typedef struct packed {
        logic load;
        logic clear;
    } timer_cmd_t;

    // States in which no memory transaction is open
    function automatic logic quiet_state(seq_state_e s);
        return (s == ST_IDLE) || (s == ST_RUN) || (s == ST_SWOUT);
    endfunction

endpackage

// File: rtl/bms_delay_timer.sv
module bms_delay_timer
    import bms_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  timer_cmd_t    cmd,
    input  logic [DW-1:0] load_val,
    input  logic          run,
    output logic          expired
);
    logic [DW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (cmd.clear)    cnt <= '0;
        else if (cmd.load)     cnt <= load_val;
        else if (run && !expired) cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/bms_pc_unit.sv
module bms_pc_unit
    import bms_pkg::*;
#(
    parameter int             AW       = 32,
    parameter logic [AW-1:0]  RESET_PC = '0,
    parameter logic [AW-1:0]  TRAP_PC  = '0,
    parameter int             STEP     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  pc_op_e        op,
    output logic [AW-1:0] pc
);
    localparam logic [AW-1:0] INC = AW'(STEP);

    always_ff @(posedge clk) begin
        if (rst) pc <= RESET_PC;
        else begin
            unique case (op)
                PC_STEP: pc <= pc + INC;
                PC_TRAP: pc <= TRAP_PC;
                default: pc <= pc;
            endcase
        end
    end
endmodule

// File: rtl/bms_err_mon.sv
module bms_err_mon
    import bms_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e st,
    input  logic       if_resp,
    input  logic       if_retry,
    input  logic       d_resp,
    input  logic       d_retry,
    output logic       err
);
    logic stray;

    always_comb begin
        stray = (if_resp  && st != ST_IWAIT)
             || (d_resp   && st != ST_DWAIT)
             || (if_retry && st != ST_IRETRY)
             || (d_retry  && st != ST_DRETRY);
    end

    always_ff @(posedge clk) begin
        if (rst)        err <= 1'b0;
        else if (stray) err <= 1'b1;
    end
endmodule

// File: rtl/blocking_mem_seq.sv
module blocking_mem_seq
    import bms_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            DW       = 8,
    parameter logic [AW-1:0] RESET_PC = 'h100,
    parameter logic [AW-1:0] TRAP_PC  = 'h200,
    parameter int            STEP     = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          activate_i,
    input  logic [DW-1:0] act_delay_i,
    input  logic          suspend_i,
    input  logic          switch_out_i,
    input  logic          take_over_i,
    input  logic          resume_i,
    input  logic          drain_req_i,
    input  logic          fetch_fault_i,
    output logic          ifetch_req_o,
    output logic [AW-1:0] ifetch_addr_o,
    input  logic          ifetch_accept_i,
    input  logic          ifetch_retry_i,
    input  logic          ifetch_resp_i,
    input  logic          dec_memref_i,
    input  logic          dec_prefetch_i,
    output logic          dmem_req_o,
    input  logic          dmem_accept_i,
    input  logic          dmem_retry_i,
    input  logic          dmem_resp_i,
    output logic [2:0]    state_o,
    output logic          retire_o,
    output logic          drain_ack_o,
    output logic          drain_done_o,
    output logic          draining_o,
    output logic          proto_err_o
);
    seq_state_e st, st_n;
    logic       go, go_n;          // a fetch is pending
    logic       drn, drn_n;        // drain deferred to next response
    logic       ack_n, done_n, ret_n;
    logic       issue, t_expired;
    timer_cmd_t tcmd;
    pc_op_e     pc_op;
    logic [AW-1:0] pc;

    bms_delay_timer #(.DW(DW)) u_timer (
        .clk(clk), .rst(rst), .cmd(tcmd), .load_val(act_delay_i),
        .run(st == ST_RUN), .expired(t_expired)
    );

    bms_pc_unit #(.AW(AW), .RESET_PC(RESET_PC), .TRAP_PC(TRAP_PC), .STEP(STEP)) u_pc (
        .clk(clk), .rst(rst), .op(pc_op), .pc(pc)
    );

    bms_err_mon u_err (
        .clk(clk), .rst(rst), .st(st),
        .if_resp(ifetch_resp_i), .if_retry(ifetch_retry_i),
        .d_resp(dmem_resp_i), .d_retry(dmem_retry_i),
        .err(proto_err_o)
    );

    always_comb begin
        st_n   = st;
        go_n   = go;
        drn_n  = drn;
        ack_n  = 1'b0;
        done_n = 1'b0;
        ret_n  = 1'b0;
        pc_op  = PC_HOLD;
        tcmd   = '0;
        ifetch_req_o = 1'b0;
        dmem_req_o   = 1'b0;
        issue = (st == ST_RUN) && go && t_expired && !suspend_i && !switch_out_i;

        unique case (st)
            ST_IDLE: begin
                if (activate_i) begin
                    st_n = ST_RUN; go_n = 1'b1; tcmd.load = 1'b1;
                end else if (switch_out_i) begin
                    st_n = ST_SWOUT; go_n = 1'b0; tcmd.clear = 1'b1;
                end
            end
            ST_RUN: begin
                if (suspend_i) begin
                    st_n = ST_IDLE; go_n = 1'b0;
                end else if (switch_out_i) begin
                    st_n = ST_SWOUT; go_n = 1'b0; tcmd.clear = 1'b1;
                end else if (issue) begin
                    if (fetch_fault_i) begin
                        pc_op = PC_TRAP; ret_n = 1'b1;
                    end else begin
                        ifetch_req_o = 1'b1;
                        st_n = ifetch_accept_i ? ST_IWAIT : ST_IRETRY;
                    end
                end
            end
            ST_IRETRY: begin
                if (ifetch_retry_i) begin
                    ifetch_req_o = 1'b1;
                    if (ifetch_accept_i) st_n = ST_IWAIT;
                end
            end
            ST_IWAIT: begin
                if (ifetch_resp_i) begin
                    st_n = ST_RUN;
                    if (drn) begin
                        done_n = 1'b1; drn_n = 1'b0; go_n = 1'b0;
                    end else if (dec_memref_i && !dec_prefetch_i) begin
                        dmem_req_o = 1'b1;
                        st_n = dmem_accept_i ? ST_DWAIT : ST_DRETRY;
                    end else begin
                        ret_n = 1'b1; pc_op = PC_STEP; go_n = 1'b1;
                    end
                end
            end
            ST_DRETRY: begin
                if (dmem_retry_i) begin
                    dmem_req_o = 1'b1;
                    if (dmem_accept_i) st_n = ST_DWAIT;
                end
            end
            ST_DWAIT: begin
                if (dmem_resp_i) begin
                    st_n = ST_RUN;
                    if (drn) begin
                        done_n = 1'b1; drn_n = 1'b0; go_n = 1'b0;
                    end else begin
                        ret_n = 1'b1; pc_op = PC_STEP; go_n = 1'b1;
                    end
                end
            end
            ST_SWOUT: begin
                if (take_over_i) begin
                    st_n = ST_RUN; go_n = 1'b0;
                end
            end
            default: st_n = ST_IDLE;
        endcase

        // A drain arriving with a response is kept for the following one
        if (drain_req_i) begin
            if (quiet_state(st)) ack_n = 1'b1;
            else                 drn_n = 1'b1;
        end

        if (resume_i && st != ST_IDLE && st != ST_SWOUT) begin
            go_n = 1'b1; tcmd.clear = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; go <= 1'b0; drn <= 1'b0;
            retire_o <= 1'b0; drain_ack_o <= 1'b0; drain_done_o <= 1'b0;
        end else begin
            st <= st_n; go <= go_n; drn <= drn_n;
            retire_o <= ret_n; drain_ack_o <= ack_n; drain_done_o <= done_n;
        end
    end

    assign ifetch_addr_o = pc;
    assign state_o       = st;
    assign draining_o    = drn;
endmodule

// File: rtl/bms_checker.sv
module bms_checker (
    input logic       clk,
    input logic       rst,
    input logic       if_req,
    input logic       if_acc,
    input logic       if_retry,
    input logic       d_req,
    input logic       d_acc,
    input logic       d_resp,
    input logic       suspend,
    input logic       take_over,
    input logic [2:0] state,
    input logic       retire,
    input logic       draining,
    input logic       drain_done,
    input logic       err
);
    p_fetch_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (if_req && if_acc && state == 3'd1) |=> state == 3'd3);

    p_fetch_refuse_r2: assert property (@(posedge clk) disable iff (rst)
        (if_req && !if_acc && state == 3'd1) |=> state == 3'd2);

    p_req_state_r3: assert property (@(posedge clk) disable iff (rst)
        if_req |-> (state == 3'd1 || state == 3'd2));

    p_retry_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd2 && !if_retry) |=> state == 3'd2);

    p_data_accept_r6: assert property (@(posedge clk) disable iff (rst)
        (d_req && d_acc) |=> state == 3'd5);

    p_dresp_retire_r7: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd5 && d_resp && !draining) |=> (retire && state == 3'd1));

    p_drain_done_r8: assert property (@(posedge clk) disable iff (rst)
        drain_done |-> (state == 3'd1 && !retire));

    p_suspend_r9: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd1 && suspend) |=> state == 3'd0);

    p_swout_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd6 && !take_over) |=> state == 3'd6);

    p_err_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

bind blocking_mem_seq bms_checker u_chk (
    .clk(clk), .rst(rst),
    .if_req(ifetch_req_o), .if_acc(ifetch_accept_i), .if_retry(ifetch_retry_i),
    .d_req(dmem_req_o), .d_acc(dmem_accept_i), .d_resp(dmem_resp_i),
    .suspend(suspend_i), .take_over(take_over_i),
    .state(state_o), .retire(retire_o), .draining(draining_o),
    .drain_done(drain_done_o), .err(proto_err_o)
);

// File: tb/sim_blocking_mem_seq.sv
`timescale 1ns/1ps
module sim_blocking_mem_seq;
    localparam logic [31:0] RPC = 32'h100;
    localparam logic [31:0] TPC = 32'h200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic activate_i, suspend_i, switch_out_i, take_over_i, resume_i, drain_req_i;
    logic fetch_fault_i, ifetch_accept_i, ifetch_retry_i, ifetch_resp_i;
    logic dec_memref_i, dec_prefetch_i, dmem_accept_i, dmem_retry_i, dmem_resp_i;
    logic [7:0] act_delay_i;
    logic ifetch_req_o, dmem_req_o, retire_o, drain_ack_o, drain_done_o, draining_o, proto_err_o;
    logic [31:0] ifetch_addr_o;
    logic [2:0] state_o;

    blocking_mem_seq u0 (.*);

    // stimulus for the next cycle
    logic s_act, s_susp, s_sw, s_take, s_res, s_drain, s_fault;
    logic s_iacc, s_iretry, s_iresp, s_mem, s_pref, s_dacc, s_dretry, s_dresp;
    logic [7:0] s_delay;

    // model state
    int m_st, m_cnt;
    logic m_go, m_drn, m_ack, m_done, m_ret, m_err;
    logic [31:0] m_pc;
    int n_st, n_cnt;
    logic n_go, n_drn, n_ack, n_done, n_ret, n_err;
    logic [31:0] n_pc;
    logic e_ifreq, e_dreq;
    logic last_ifreq, last_dreq;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic quiet(int s);
        return s == 0 || s == 1 || s == 6;
    endfunction

    task automatic clear_stim();
        s_act = 0; s_susp = 0; s_sw = 0; s_take = 0; s_res = 0; s_drain = 0; s_fault = 0;
        s_iacc = 0; s_iretry = 0; s_iresp = 0; s_mem = 0; s_pref = 0;
        s_dacc = 0; s_dretry = 0; s_dresp = 0; s_delay = 0;
    endtask

    // next model state, written from the requirements
    task automatic model_next();
        logic iss;
        n_st = m_st; n_go = m_go; n_drn = m_drn; n_cnt = m_cnt; n_pc = m_pc;
        n_ack = 0; n_done = 0; n_ret = 0; n_err = m_err;
        e_ifreq = 0; e_dreq = 0;
        iss = (m_st == 1) && m_go && (m_cnt == 0) && !s_susp && !s_sw;
        if ((s_iresp && m_st != 3) || (s_dresp && m_st != 5) ||
            (s_iretry && m_st != 2) || (s_dretry && m_st != 4)) n_err = 1;
        if (m_st == 1 && m_cnt != 0) n_cnt = m_cnt - 1;
        case (m_st)
            0: if (s_act) begin n_st = 1; n_go = 1; n_cnt = s_delay; end
               else if (s_sw) begin n_st = 6; n_go = 0; n_cnt = 0; end
            1: if (s_susp) begin n_st = 0; n_go = 0; end
               else if (s_sw) begin n_st = 6; n_go = 0; n_cnt = 0; end
               else if (iss) begin
                   if (s_fault) begin n_pc = TPC; n_ret = 1; end
                   else begin e_ifreq = 1; n_st = s_iacc ? 3 : 2; end
               end
            2: if (s_iretry) begin e_ifreq = 1; if (s_iacc) n_st = 3; end
            3: if (s_iresp) begin
                   n_st = 1;
                   if (m_drn) begin n_done = 1; n_drn = 0; n_go = 0; end
                   else if (s_mem && !s_pref) begin e_dreq = 1; n_st = s_dacc ? 5 : 4; end
                   else begin n_ret = 1; n_pc = m_pc + 4; n_go = 1; end
               end
            4: if (s_dretry) begin e_dreq = 1; if (s_dacc) n_st = 5; end
            5: if (s_dresp) begin
                   n_st = 1;
                   if (m_drn) begin n_done = 1; n_drn = 0; n_go = 0; end
                   else begin n_ret = 1; n_pc = m_pc + 4; n_go = 1; end
               end
            6: if (s_take) begin n_st = 1; n_go = 0; end
            default: ;
        endcase
        if (s_drain) begin
            if (quiet(m_st)) n_ack = 1; else n_drn = 1;
        end
        if (s_res && m_st != 0 && m_st != 6) begin n_go = 1; n_cnt = 0; end
    endtask

    task automatic model_reset();
        m_st = 0; m_cnt = 0; m_go = 0; m_drn = 0; m_ack = 0; m_done = 0;
        m_ret = 0; m_err = 0; m_pc = RPC;
    endtask

    task automatic cyc();
        @(negedge clk);
        activate_i = s_act; act_delay_i = s_delay; suspend_i = s_susp;
        switch_out_i = s_sw; take_over_i = s_take; resume_i = s_res;
        drain_req_i = s_drain; fetch_fault_i = s_fault;
        ifetch_accept_i = s_iacc; ifetch_retry_i = s_iretry; ifetch_resp_i = s_iresp;
        dec_memref_i = s_mem; dec_prefetch_i = s_pref;
        dmem_accept_i = s_dacc; dmem_retry_i = s_dretry; dmem_resp_i = s_dresp;
        #1;
        model_next();
        chk("R2 ifetch_req", {31'd0, ifetch_req_o}, {31'd0, e_ifreq});
        if (e_ifreq) chk("R2 ifetch_addr", ifetch_addr_o, m_pc);
        chk("R5 dmem_req", {31'd0, dmem_req_o}, {31'd0, e_dreq});
        last_ifreq = ifetch_req_o; last_dreq = dmem_req_o;
        @(posedge clk); #1;
        m_st = n_st; m_go = n_go; m_drn = n_drn; m_cnt = n_cnt; m_pc = n_pc;
        m_ack = n_ack; m_done = n_done; m_ret = n_ret; m_err = n_err;
        chk("R3 state", {29'd0, state_o}, m_st);
        chk("R7 pc", ifetch_addr_o, m_pc);
        chk("R5 retire", {31'd0, retire_o}, {31'd0, m_ret});
        chk("R8 drain_ack", {31'd0, drain_ack_o}, {31'd0, m_ack});
        chk("R8 drain_done", {31'd0, drain_done_o}, {31'd0, m_done});
        chk("R8 draining", {31'd0, draining_o}, {31'd0, m_drn});
        chk("R12 proto_err", {31'd0, proto_err_o}, {31'd0, m_err});
        clear_stim();
    endtask

    task automatic do_reset();
        clear_stim();
        @(negedge clk);
        rst = 1;
        activate_i = 0; act_delay_i = 0; suspend_i = 0; switch_out_i = 0; take_over_i = 0;
        resume_i = 0; drain_req_i = 0; fetch_fault_i = 0; ifetch_accept_i = 0;
        ifetch_retry_i = 0; ifetch_resp_i = 0; dec_memref_i = 0; dec_prefetch_i = 0;
        dmem_accept_i = 0; dmem_retry_i = 0; dmem_resp_i = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int seen;
        void'($urandom(32'd2024));
        do_reset();
        // R1 reset state
        chk("R1 state", {29'd0, state_o}, 0);
        chk("R1 pc", ifetch_addr_o, RPC);
        chk("R1 ifetch_req", {31'd0, ifetch_req_o}, 0);
        chk("R1 flags", {28'd0, draining_o, proto_err_o, retire_o, drain_done_o}, 0);

        // R10 activation delay of 3
        s_act = 1; s_delay = 3; cyc();
        seen = -1;
        for (int k = 0; k < 10; k++) begin
            s_iacc = 1; cyc();
            if (last_ifreq) begin seen = k; break; end
        end
        chk("R10 delay cycles", seen, 3);
        // R5 non-memory instruction retires
        s_iresp = 1; cyc();
        chk("R5 retire pc", ifetch_addr_o, RPC + 4);
        // R2 refused fetch
        cyc();
        chk("R2 refused to retry", {29'd0, state_o}, 2);
        // R3 retry rules
        cyc();
        chk("R3 silent without retry", {31'd0, last_ifreq}, 0);
        s_iretry = 1; cyc();
        chk("R3 retry refused stays", {29'd0, state_o}, 2);
        s_iretry = 1; s_iacc = 1; cyc();
        chk("R3 retry accepted", {29'd0, state_o}, 3);
        // R6 data refused then retried
        s_iresp = 1; s_mem = 1; cyc();
        chk("R6 data refused", {29'd0, state_o}, 4);
        s_dretry = 1; s_dacc = 1; cyc();
        chk("R6 data retry accepted", {29'd0, state_o}, 5);
        // R7 data response
        s_dresp = 1; cyc();
        chk("R7 data retire pc", ifetch_addr_o, RPC + 8);
        s_iacc = 1; cyc();
        chk("R7 next fetch at once", {31'd0, last_ifreq}, 1);
        // R5 prefetch completes with no data request
        s_iresp = 1; s_mem = 1; s_pref = 1; cyc();
        chk("R5 prefetch no dreq", {31'd0, last_dreq}, 0);
        // R4 fetch fault
        s_fault = 1; cyc();
        chk("R4 fault pc", ifetch_addr_o, TPC);
        chk("R4 fault no req", {31'd0, last_ifreq}, 0);
        s_iacc = 1; cyc();
        chk("R4 refetch", {31'd0, last_ifreq}, 1);
        // R8 drain deferred to response
        s_drain = 1; cyc();
        chk("R8 draining set", {31'd0, draining_o}, 1);
        s_iresp = 1; s_mem = 1; cyc();
        chk("R8 drain done no retire", {30'd0, drain_done_o, retire_o}, 2);
        chk("R8 pc unchanged", ifetch_addr_o, TPC);
        s_iacc = 1; cyc();
        chk("R8 no fetch after drain", {31'd0, last_ifreq}, 0);
        s_drain = 1; cyc();
        chk("R8 immediate ack", {31'd0, drain_ack_o}, 1);
        s_res = 1; cyc();
        s_iacc = 1; cyc();
        chk("R11 resume restarts", {31'd0, last_ifreq}, 1);
        // R8 drain arriving with the response is kept for the next one
        s_drain = 1; s_iresp = 1; cyc();
        chk("R8 same-cycle drain retires", {30'd0, retire_o, draining_o}, 3);
        // R9 suspend
        s_susp = 1; cyc();
        chk("R9 suspend", {29'd0, state_o}, 0);
        chk("R9 no fetch when suspending", {31'd0, last_ifreq}, 0);
        s_susp = 1; cyc();
        chk("R9 ignored in idle", {29'd0, state_o}, 0);
        // R10 zero delay and ignored activate
        s_act = 1; s_delay = 0; cyc();
        s_iacc = 1; cyc();
        chk("R10 zero delay fetch", {31'd0, last_ifreq}, 1);
        s_act = 1; cyc();
        chk("R10 activate ignored", {29'd0, state_o}, 3);
        // R11 switch-out cancels a delayed fetch
        s_iresp = 1; cyc();
        chk("R8 pending drain taken", {31'd0, drain_done_o}, 1);
        s_susp = 1; cyc();
        s_act = 1; s_delay = 5; cyc();
        cyc();
        s_sw = 1; cyc();
        chk("R11 switched out", {29'd0, state_o}, 6);
        s_res = 1; cyc();
        chk("R11 resume ignored", {29'd0, state_o}, 6);
        s_take = 1; cyc();
        chk("R11 take over", {29'd0, state_o}, 1);
        for (int k = 0; k < 7; k++) begin
            s_iacc = 1; cyc();
            chk("R11 no fetch after take over", {31'd0, last_ifreq}, 0);
        end
        s_res = 1; cyc();
        s_iacc = 1; cyc();
        chk("R11 fetch after resume", {31'd0, last_ifreq}, 1);
        // R12 stray response
        s_dresp = 1; cyc();
        chk("R12 error set", {31'd0, proto_err_o}, 1);
        s_iresp = 1; cyc();
        chk("R12 error sticky", {31'd0, proto_err_o}, 1);

        // constrained random phase
        do_reset();
        for (int i = 0; i < 4000; i++) begin
            s_iacc  = ($urandom % 10) < 6;
            s_dacc  = ($urandom % 10) < 6;
            s_mem   = ($urandom % 2) == 0;
            s_pref  = ($urandom % 5) == 0;
            s_fault = ($urandom % 12) == 0;
            s_delay = 8'($urandom % 6);
            s_susp  = ($urandom % 60) == 0;
            s_sw    = ($urandom % 80) == 0;
            s_res   = ($urandom % 15) == 0;
            s_drain = ($urandom % 30) == 0;
            case (m_st)
                0: s_act = ($urandom % 4) == 0;
                2: s_iretry = ($urandom % 2) == 0;
                3: s_iresp = ($urandom % 3) == 0;
                4: s_dretry = ($urandom % 2) == 0;
                5: s_dresp = ($urandom % 3) == 0;
                6: s_take = ($urandom % 4) == 0;
                default: ;
            endcase
            if (i > 3500 && ($urandom % 100) == 0) s_iresp = 1;
            cyc();
        end

        summary();
        $finish;
    end
endmodule